// File: doc/BRIEF.md
# Legacy System Control Port Block

This block sits on a byte-wide I/O bus inside a PC-style chipset and owns three fixed legacy ports. The first is a control byte that drives the A20 address gate and issues a system reset request. The second is a write-only clear port for a latched floating-point error interrupt. The third is a diagnostic port whose writes are accepted and thrown away. The bus is a plain address, write data, read data, read strobe and write strobe interface. There is no handshake, and each strobe marks one single-byte access in that clock cycle.

The control byte has two kinds of reset. Power-on reset (`por_n`, asynchronous, active low) clears the whole byte. Device reset (`dev_rst`, synchronous) clears only the reset-request bit, so the A20 setting survives a warm reset. The error interrupt is raised by a one-cycle pulse on `ferr_raise`. It stays high until software writes the clear port.

Top module: `syscp_legacy_ports`

## Requirements
- R1: A write strobe at address 0x92 stores the full data byte. A read at 0x92 returns the stored byte unchanged on `io_rdata` in the same cycle as the read strobe. A read has no side effect.
- R2: `a20_gate` equals bit 1 of the stored control byte. It changes in the cycle after the write that sets it.
- R3: A write at 0x92 with data bit 0 set produces `reset_req` high for exactly one cycle, the cycle after the write. A write with bit 0 clear produces no pulse.
- R4: `dev_rst` clears bit 0 of the stored byte and keeps bits 7..1 and `a20_gate`. A control write in the same cycle as `dev_rst` is discarded and produces no reset pulse.
- R5: While `por_n` is low, the stored byte is 0x00 and `a20_gate`, `reset_req` and `ferr_irq` are all low.
- R6: A `ferr_raise` pulse sets `ferr_irq` in the following cycle. `ferr_irq` then stays high with no further pulse until it is cleared.
- R7: Any write at 0xF0 clears `ferr_irq` in the following cycle, whatever the data value.
- R8: When `ferr_raise` and a write at 0xF0 fall in the same cycle, `ferr_irq` is high afterwards.
- R9: A write at 0x80 changes neither the stored control byte, `a20_gate`, `reset_req` nor `ferr_irq`.
- R10: `io_rdata` is 0xFF whenever the read strobe does not address 0x92, including reads of 0x80 and 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| dev_rst | input | 1 | Synchronous device (warm) reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data byte |
| ferr_raise | input | 1 | Pulse that latches the error interrupt |
| a20_gate | output | 1 | A20 gate level |
| reset_req | output | 1 | One-cycle system reset request |
| ferr_irq | output | 1 | Latched floating-point error interrupt level |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high together. They also assume that each strobe describes a complete single-byte access in one cycle, so that a write cycle can be tied directly to the output it updates one cycle later. The stimulus keeps to this rule: every bus operation drives exactly one strobe, or none, for one cycle. Device reset and error raise are applied both alone and in the same cycle as colliding writes, so that the priority rules are exercised.

// File: rtl/syscp_pkg.sv
`timescale 1ns/1ps
package syscp_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_FERR = 2'd2,
      SEL_DIAG = 2'd3
   } port_sel_e;

   typedef struct packed {
      logic      wr;
      logic      rd;
      port_sel_e sel;
   } access_t;

endpackage

// File: rtl/syscp_decode.sv
`timescale 1ns/1ps
module syscp_decode
   import syscp_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int unsigned CTRL_ADDR = 'h92,
   parameter int unsigned FERR_ADDR = 'hF0,
   parameter int unsigned DIAG_ADDR = 'h80
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output access_t           acc
);

   localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] FA = ADDR_W'(FERR_ADDR);
   localparam logic [ADDR_W-1:0] DA = ADDR_W'(DIAG_ADDR);

   always_comb begin
      acc.wr  = io_wr;
      acc.rd  = io_rd;
      acc.sel = SEL_NONE;
      if (io_addr == CA)      acc.sel = SEL_CTRL;
      else if (io_addr == FA) acc.sel = SEL_FERR;
      else if (io_addr == DA) acc.sel = SEL_DIAG;
   end

endmodule

// File: rtl/syscp_ctrl_reg.sv
`timescale 1ns/1ps
module syscp_ctrl_reg #(
   parameter int DATA_W  = 8,
   parameter int A20_BIT = 1,
   parameter int RST_BIT = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              dev_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q,
   output logic              a20,
   output logic              rst_pulse
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         q         <= '0;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= wr_en & ~dev_rst & wdata[RST_BIT];
         if (dev_rst)
            q[RST_BIT] <= 1'b0;
         else if (wr_en)
            q <= wdata;
      end
   end

   assign a20 = q[A20_BIT];

endmodule

// File: rtl/syscp_ferr_latch.sv
`timescale 1ns/1ps
module syscp_ferr_latch (
   input  logic clk,
   input  logic por_n,
   input  logic raise,
   input  logic clear,
   output logic level
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         level <= 1'b0;
      else if (raise)
         level <= 1'b1;
      else if (clear)
         level <= 1'b0;
   end

endmodule

// File: rtl/syscp_rd_mux.sv
`timescale 1ns/1ps
module syscp_rd_mux #(
   parameter int              DATA_W   = 8,
   parameter logic [DATA_W-1:0] IDLE_VAL = '1,
   parameter bit              REG_READ = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] val,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (REG_READ) begin : g_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) rdata_q <= IDLE_VAL;
            else        rdata_q <= hit ? val : IDLE_VAL;
         end
         assign rdata = rdata_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk & por_n;
         assign rdata = hit ? val : IDLE_VAL;
      end
   endgenerate

endmodule

// File: rtl/syscp_legacy_ports.sv
`timescale 1ns/1ps
module syscp_legacy_ports
   import syscp_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 'h92,
   parameter int unsigned FERR_ADDR = 'hF0,
   parameter int unsigned DIAG_ADDR = 'h80,
   parameter int          A20_BIT   = 1,
   parameter int          RST_BIT   = 0,
   parameter bit          REG_READ  = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              dev_rst,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              ferr_raise,
   output logic              a20_gate,
   output logic              reset_req,
   output logic              ferr_irq
);

   localparam logic [DATA_W-1:0] IDLE_VAL  = '1;
   localparam longint unsigned   ADDR_SPAN = 64'd1 << ADDR_W;

   generate
      if (DATA_W < 2 || A20_BIT >= DATA_W || RST_BIT >= DATA_W || A20_BIT == RST_BIT) begin : g_bad_bits
         $error("control bit positions must be distinct and inside DATA_W");
      end
      if (CTRL_ADDR >= ADDR_SPAN || FERR_ADDR >= ADDR_SPAN || DIAG_ADDR >= ADDR_SPAN) begin : g_bad_span
         $error("port address does not fit in ADDR_W");
      end
      if (CTRL_ADDR == FERR_ADDR || CTRL_ADDR == DIAG_ADDR || FERR_ADDR == DIAG_ADDR) begin : g_bad_map
         $error("port addresses must be distinct");
      end
   endgenerate

   access_t           acc;
   logic              wr_ctrl;
   logic              wr_ferr;
   logic              rd_ctrl;
   logic [DATA_W-1:0] ctrl_q;

   syscp_decode #(
      .ADDR_W   (ADDR_W),
      .CTRL_ADDR(CTRL_ADDR),
      .FERR_ADDR(FERR_ADDR),
      .DIAG_ADDR(DIAG_ADDR)
   ) u_dec (
      .io_addr(io_addr),
      .io_wr  (io_wr),
      .io_rd  (io_rd),
      .acc    (acc)
   );

   assign wr_ctrl = acc.wr && (acc.sel == SEL_CTRL);
   assign wr_ferr = acc.wr && (acc.sel == SEL_FERR);
   assign rd_ctrl = acc.rd && (acc.sel == SEL_CTRL);

   syscp_ctrl_reg #(
      .DATA_W (DATA_W),
      .A20_BIT(A20_BIT),
      .RST_BIT(RST_BIT)
   ) u_ctrl (
      .clk      (clk),
      .por_n    (por_n),
      .dev_rst  (dev_rst),
      .wr_en    (wr_ctrl),
      .wdata    (io_wdata),
      .q        (ctrl_q),
      .a20      (a20_gate),
      .rst_pulse(reset_req)
   );

   syscp_ferr_latch u_ferr (
      .clk  (clk),
      .por_n(por_n),
      .raise(ferr_raise),
      .clear(wr_ferr),
      .level(ferr_irq)
   );

   syscp_rd_mux #(
      .DATA_W  (DATA_W),
      .IDLE_VAL(IDLE_VAL),
      .REG_READ(REG_READ)
   ) u_rd (
      .clk  (clk),
      .por_n(por_n),
      .hit  (rd_ctrl),
      .val  (ctrl_q),
      .rdata(io_rdata)
   );

endmodule

// File: rtl/syscp_legacy_ports_chk.sv
`timescale 1ns/1ps
module syscp_legacy_ports_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 'h92,
   parameter int unsigned FERR_ADDR = 'hF0,
   parameter int unsigned DIAG_ADDR = 'h80,
   parameter int          A20_BIT   = 1,
   parameter int          RST_BIT   = 0
) (
   input logic              clk,
   input logic              por_n,
   input logic              dev_rst,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_wr,
   input logic              ferr_raise,
   input logic              a20_gate,
   input logic              reset_req,
   input logic              ferr_irq
);

   localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] FA = ADDR_W'(FERR_ADDR);
   localparam logic [ADDR_W-1:0] DA = ADDR_W'(DIAG_ADDR);

   // R3
   reset_src_chk: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |-> $past(io_wr && io_addr == CA && io_wdata[RST_BIT] && !dev_rst));

   // R2
   a20_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
      (io_wr && io_addr == CA && !dev_rst) |=> (a20_gate == $past(io_wdata[A20_BIT])));

   // R4
   devrst_a20_chk: assert property (@(posedge clk) disable iff (!por_n)
      dev_rst |=> $stable(a20_gate));

   // R4
   devrst_nopulse_chk: assert property (@(posedge clk) disable iff (!por_n)
      dev_rst |=> !reset_req);

   // R6
   ferr_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      ferr_raise |=> ferr_irq);

   // R6
   ferr_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (ferr_irq && !ferr_raise && !(io_wr && io_addr == FA)) |=> ferr_irq);

   // R7
   ferr_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
      (io_wr && io_addr == FA && !ferr_raise) |=> !ferr_irq);

   // R9
   diag_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      (io_wr && io_addr == DA && !ferr_raise) |=>
         ($stable(a20_gate) && $stable(ferr_irq) && !reset_req));

endmodule

bind syscp_legacy_ports syscp_legacy_ports_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CTRL_ADDR(CTRL_ADDR),
   .FERR_ADDR(FERR_ADDR),
   .DIAG_ADDR(DIAG_ADDR),
   .A20_BIT  (A20_BIT),
   .RST_BIT  (RST_BIT)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .dev_rst   (dev_rst),
   .io_addr   (io_addr),
   .io_wdata  (io_wdata),
   .io_wr     (io_wr),
   .ferr_raise(ferr_raise),
   .a20_gate  (a20_gate),
   .reset_req (reset_req),
   .ferr_irq  (ferr_irq)
);

// File: tb/sim_syscp_legacy_ports.sv
`timescale 1ns/1ps
module sim_syscp_legacy_ports;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        dev_rst = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        ferr_raise = 1'b0;
   logic        a20_gate;
   logic        reset_req;
   logic        ferr_irq;

   always #2.5 clk = ~clk;

   syscp_legacy_ports u0 (
      .clk       (clk),
      .por_n     (por_n),
      .dev_rst   (dev_rst),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_rdata  (io_rdata),
      .ferr_raise(ferr_raise),
      .a20_gate  (a20_gate),
      .reset_req (reset_req),
      .ferr_irq  (ferr_irq)
   );

   typedef struct {
      int         at;
      int         sig;
      logic [7:0] exp;
      string      req;
   } exp_t;

   exp_t       sb[$];
   int         cyc = 0;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;
   logic [7:0] m_reg = 8'h00;
   logic       m_ferr = 1'b0;

   task automatic push(input int s, input logic [7:0] e, input string r);
      exp_t it;
      it.at  = cyc + 1;
      it.sig = s;
      it.exp = e;
      it.req = r;
      sb.push_back(it);
   endtask

   // one bus cycle; expectations come from the requirements, not the RTL
   task automatic op(input logic w, input logic r, input logic [15:0] a,
                     input logic [7:0] d, input logic rz, input logic dr,
                     input logic pn, input string tag);
      logic rr;
      @(negedge clk);
      io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
      ferr_raise = rz; dev_rst = dr; por_n = pn;
      rr = 1'b0;
      if (!pn) begin
         m_reg  = 8'h00;
         m_ferr = 1'b0;
      end else begin
         rr = w && a == 16'h0092 && d[0] && !dr;
         if (dr) m_reg[0] = 1'b0;
         else if (w && a == 16'h0092) m_reg = d;
         if (rz) m_ferr = 1'b1;
         else if (w && a == 16'h00F0) m_ferr = 1'b0;
      end
      push(0, (r && a == 16'h0092) ? m_reg : 8'hFF, {tag, " rdata"});
      push(1, {7'b0, m_reg[1]}, {tag, " a20_gate"});
      push(2, {7'b0, rr}, {tag, " reset_req"});
      push(3, {7'b0, m_ferr}, {tag, " ferr_irq"});
   endtask

   task automatic idle(input string tag);
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, tag);
   endtask
   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
      op(1'b1, 1'b0, a, d, 1'b0, 1'b0, 1'b1, tag);
   endtask
   task automatic rd(input logic [15:0] a, input string tag);
      op(1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0, 1'b1, tag);
   endtask

   // monitor: pops expectations and compares them just after each edge
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         while (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t       it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.sig)
               0:       act = io_rdata;
               1:       act = {7'b0, a20_gate};
               2:       act = {7'b0, reset_req};
               default: act = {7'b0, ferr_irq};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      // R5 power-on state
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R5 por");
      op(1'b0, 1'b1, 16'h0092, 8'h00, 1'b0, 1'b0, 1'b0, "R5 por read");
      idle("R5 after por");
      rd(16'h0092, "R5 byte zero");

      // R1 R2: store, readback, a20 follows bit1
      wr(16'h0092, 8'hA6, "R2 write A6");
      rd(16'h0092, "R1 read A6");
      rd(16'h0092, "R1 read again");
      wr(16'h0092, 8'h00, "R2 a20 low");
      wr(16'h0092, 8'h5E, "R2 a20 high");
      rd(16'h0092, "R1 read 5E");

      // R3 reset pulse
      wr(16'h0092, 8'h03, "R3 pulse write");
      idle("R3 pulse ends");
      wr(16'h0092, 8'h81, "R3 second pulse");
      wr(16'h0092, 8'h83, "R3 back to back");
      wr(16'h0092, 8'h82, "R3 no pulse");
      wr(16'h0092, 8'h0B, "R3 pulse 0B");

      // R4 device reset
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, "R4 dev reset");
      rd(16'h0092, "R4 bit0 only cleared");
      op(1'b1, 1'b0, 16'h0092, 8'hF5, 1'b0, 1'b1, 1'b1, "R4 write dropped");
      rd(16'h0092, "R4 byte kept");

      // R6 R7 R8 error latch
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b1, "R6 raise");
      idle("R6 hold");
      idle("R6 hold 2");
      wr(16'h00F0, 8'h00, "R7 clear 00");
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b1, "R6 raise again");
      wr(16'h00F0, 8'hFF, "R7 clear FF");
      op(1'b1, 1'b0, 16'h00F0, 8'h55, 1'b1, 1'b0, 1'b1, "R8 raise wins");
      idle("R8 stays high");

      // R9 diagnostic writes while ferr high
      wr(16'h0080, 8'h01, "R9 diag 01");
      wr(16'h0080, 8'hFF, "R9 diag FF");
      wr(16'h0080, 8'h00, "R9 diag 00");
      rd(16'h0092, "R9 byte untouched");
      wr(16'h00F0, 8'h3C, "R7 clear 3C");
      wr(16'h0080, 8'h03, "R9 diag with ferr low");

      // R10 idle readback
      rd(16'h0080, "R10 read 80");
      rd(16'h00F0, "R10 read F0");
      rd(16'h0093, "R10 read 93");
      rd(16'h0092, "R1 read after R10");

      // R5 power-on clears whole byte and ferr
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b1, "R6 raise before por");
      op(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R5 por again");
      rd(16'h0092, "R5 byte cleared");
      idle("R5 tail");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual=%0d expected=0 pending", sb.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule